// File: doc/BRIEF.md
# Machine Check Entry Controller

This block decides how a 32-bit core reacts when a machine check event is signalled. In the cycle the event is presented, the block looks at the current machine state word, the debug-mode enable and two debug enable bits. It then picks exactly one of three reactions: take the exception, drop into debug mode, or stop the processor in checkstop.

When the exception is taken, the block computes the saved program counter and the saved status word. It also computes the new machine state word, the fetch redirect address and, for load/store errors only, the data-error status word and the data address. All of these are presented together with a one-cycle redirect strobe. When checkstop is chosen, a sticky checkstop flag rises and a freeze output follows within two cycles of entry. Only reset leaves checkstop.

All register bit numbers below are big-endian: bit 0 is the most significant bit of a 32-bit word. Bits used in the machine state word (MSR): ILE = bit 15, ME = bit 19, IP = bit 25, LE = bit 31.

Top module: `mce_entry_ctrl`

## Requirements
- R1: An event with MSR.ME=1, where it is not the case that both debug mode and the debug machine-check enable are 1, produces redirect_o=1 and no other reaction, one cycle after the event.
- R2: An event with MSR.ME=0, where debug mode is 0 or the debug checkstop enable is 0, sets checkstop_o=1 one cycle after the event, with no redirect and no debug pulse.
- R3: An event with debug mode=1 and either (ME=0 and checkstop enable=1) or (ME=1 and machine-check enable=1) produces debug_entry_o=1 for one cycle, and nothing else.
- R4: On redirect, redirect_pc_o equals 0x00000200 when MSR.IP=0 and 0xFFF00200 when MSR.IP=1.
- R5: On redirect, srr0_o equals the effective address of the faulting instruction.
- R6: On redirect, SRR1 bit 0 and bits 2..15 are 0, bit 1 is 1 for a fetch error and 0 for a load/store error, and bits 16..31 equal MSR bits 16..31.
- R7: On redirect, the new MSR has IP unchanged, LE equal to the old ILE, and every other bit (ME included) zero.
- R8: For a load/store error, DSISR bits 15..16 take instruction bits 29..30 when x_form_i=1 and 00 otherwise. DSISR bit 17 takes instruction bit 25 (X-form) or bit 5 (D-form). Bits 22..31 take instruction bits 6..15. All other DSISR bits are zero.
- R9: dsisr_dar_we_o pulses with the redirect only for a load/store error, and then dar_o equals the data effective address. A fetch error leaves dsisr_dar_we_o at 0.
- R10: Once set, checkstop_o stays 1 until reset. Later events cause no redirect or debug pulse. freeze_o is 1 no later than the second cycle after checkstop entry.
- R11: After reset, redirect_o, debug_entry_o, dsisr_dar_we_o, checkstop_o and freeze_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_event_i | input | 1 | Machine check event, one cycle |
| fetch_err_i | input | 1 | 1 = instruction fetch error, 0 = load/store error |
| x_form_i | input | 1 | 1 = faulting instruction is X-form, 0 = D-form |
| insn_i | input | 32 | Faulting instruction word |
| insn_ea_i | input | 32 | Effective address of faulting instruction |
| data_ea_i | input | 32 | Effective address of the data access |
| msr_i | input | 32 | Current machine state word |
| dbg_mode_en_i | input | 1 | Debug mode enabled |
| dbg_stop_en_i | input | 1 | Debug enable: route checkstop to debug |
| dbg_mc_en_i | input | 1 | Debug enable: route machine check to debug |
| redirect_o | output | 1 | One-cycle redirect and register write strobe |
| redirect_pc_o | output | 32 | Vector fetch address |
| srr0_o | output | 32 | New saved program counter |
| srr1_o | output | 32 | New saved status word |
| msr_o | output | 32 | New machine state word |
| dsisr_dar_we_o | output | 1 | Write strobe for DSISR and DAR |
| dsisr_o | output | 32 | New data-error status word |
| dar_o | output | 32 | New data address |
| debug_entry_o | output | 1 | One-cycle debug-mode entry pulse |
| checkstop_o | output | 1 | Sticky checkstop state |
| freeze_o | output | 1 | Freeze request for core state |

## Verification
The hardest situation to reach is an event that arrives while the block is already in checkstop. From outside, such an event looks exactly like a normal exception request. The bench reaches it by first putting the block into checkstop through every ME and debug-enable combination that selects it. It then sends a second event with ME forced to 1, which on its own would be taken, and checks that neither a redirect nor a debug pulse appears. The full sweep covers all 256 combinations of ME, debug mode, both debug enables, IP, ILE, error source and instruction form. Each combination uses a scrambled instruction word and state word.

// File: rtl/mce_pkg.sv
// Package: shared types and bit positions for the machine check entry block.
// Assumes big-endian numbering: bit 0 is the most significant bit.
package mce_pkg;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned MSR_ILE_BE = 15;
    localparam int unsigned MSR_ME_BE  = 19;
    localparam int unsigned MSR_IP_BE  = 25;
    localparam int unsigned MSR_LE_BE  = 31;

    typedef enum logic [1:0] {
        MC_TAKE  = 2'd0,
        MC_STOP  = 2'd1,
        MC_DEBUG = 2'd2
    } mc_outcome_e;

    // Map a big-endian bit number to a vector index.
    function automatic int unsigned be(input int unsigned b);
        return XLEN - 1 - b;
    endfunction
endpackage

// File: rtl/mce_outcome_sel.sv
// Module: chooses take / checkstop / debug for a machine check event.
// Assumes the three cases are exhaustive and mutually exclusive.
module mce_outcome_sel
    import mce_pkg::*;
(
    input  logic        me_i,
    input  logic        dbg_mode_en_i,
    input  logic        dbg_stop_en_i,
    input  logic        dbg_mc_en_i,
    output mc_outcome_e outcome_o
);
    logic to_debug;
    logic to_stop;

    // Purpose: evaluate the debug and checkstop routing conditions.
    always_comb begin
        to_debug = dbg_mode_en_i &&
                   ((!me_i && dbg_stop_en_i) || (me_i && dbg_mc_en_i));
        to_stop  = !me_i && (!dbg_mode_en_i || !dbg_stop_en_i);
        if (to_debug)     outcome_o = MC_DEBUG;
        else if (to_stop) outcome_o = MC_STOP;
        else              outcome_o = MC_TAKE;
    end
endmodule

// File: rtl/mce_frame_build.sv
// Module: builds SRR1, new MSR, DSISR and the vector address for a taken exception.
// Purely combinational; assumes big-endian bit numbering from mce_pkg.
module mce_frame_build
    import mce_pkg::*;
#(
    parameter logic [XLEN-1:0] LOW_BASE   = 32'h0000_0000,
    parameter logic [XLEN-1:0] HIGH_BASE  = 32'hFFF0_0000,
    parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0200,
    parameter int unsigned     DS_FIELD_W = 10
) (
    input  logic [XLEN-1:0] msr_i,
    input  logic [XLEN-1:0] insn_i,
    input  logic            fetch_err_i,
    input  logic            x_form_i,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] dsisr_o,
    output logic [XLEN-1:0] vector_o
);
    localparam int unsigned HALF = XLEN / 2;

    // Purpose: saved status word, low half copied from the MSR.
    always_comb begin
        srr1_o = '0;
        srr1_o[be(1)] = fetch_err_i;
        for (int unsigned k = HALF; k < XLEN; k++)
            srr1_o[be(k)] = msr_i[be(k)];
    end

    // Purpose: new MSR keeps IP, loads LE from ILE, clears everything else.
    always_comb begin
        msr_o = '0;
        msr_o[be(MSR_IP_BE)] = msr_i[be(MSR_IP_BE)];
        msr_o[be(MSR_LE_BE)] = msr_i[be(MSR_ILE_BE)];
    end

    // Purpose: DSISR fields picked from the instruction by form.
    always_comb begin
        dsisr_o = '0;
        if (x_form_i) begin
            dsisr_o[be(15)] = insn_i[be(29)];
            dsisr_o[be(16)] = insn_i[be(30)];
            dsisr_o[be(17)] = insn_i[be(25)];
        end else begin
            dsisr_o[be(17)] = insn_i[be(5)];
        end
        for (int unsigned k = 0; k < DS_FIELD_W; k++)
            dsisr_o[be(22 + k)] = insn_i[be(6 + k)];
    end

    // Purpose: vector fetch address from the IP-selected base.
    always_comb begin
        vector_o = (msr_i[be(MSR_IP_BE)] ? HIGH_BASE : LOW_BASE) + VEC_OFFSET;
    end
endmodule

// File: rtl/mce_stop_hold.sv
// Module: sticky checkstop state and delayed freeze request.
// Assumes FREEZE_DLY is 1 or 2 so freeze rises within two cycles of entry.
module mce_stop_hold
#(
    parameter int unsigned FREEZE_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    output logic checkstop_o,
    output logic freeze_o
);
    localparam int unsigned CNT_W = $clog2(FREEZE_DLY + 1);
    logic [CNT_W-1:0] dly_cnt;

    // Purpose: set checkstop on entry and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       checkstop_o <= 1'b0;
        else if (enter_i) checkstop_o <= 1'b1;
    end

    // Purpose: count checkstop cycles and raise freeze after FREEZE_DLY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt  <= '0;
            freeze_o <= 1'b0;
        end else if (checkstop_o && !freeze_o) begin
            dly_cnt <= dly_cnt + 1'b1;
            if (dly_cnt == CNT_W'(FREEZE_DLY - 1)) freeze_o <= 1'b1;
        end
    end

    // R10
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> checkstop_o);
    // R10
    freeze_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o && $past(checkstop_o) && $past(checkstop_o, 2) |-> freeze_o);
    // R10
    freeze_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_o |-> checkstop_o);
endmodule

// File: rtl/mce_entry_ctrl.sv
// Module: machine check entry controller, top level.
// Registers the chosen reaction and the exception frame one cycle after the event.
// Assumes mc_event_i lasts one cycle and inputs are stable while it is high.
module mce_entry_ctrl
    import mce_pkg::*;
#(
    parameter logic [31:0] LOW_BASE   = 32'h0000_0000,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0200,
    parameter int unsigned FREEZE_DLY = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mc_event_i,
    input  logic        fetch_err_i,
    input  logic        x_form_i,
    input  logic [31:0] insn_i,
    input  logic [31:0] insn_ea_i,
    input  logic [31:0] data_ea_i,
    input  logic [31:0] msr_i,
    input  logic        dbg_mode_en_i,
    input  logic        dbg_stop_en_i,
    input  logic        dbg_mc_en_i,
    output logic        redirect_o,
    output logic [31:0] redirect_pc_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic        dsisr_dar_we_o,
    output logic [31:0] dsisr_o,
    output logic [31:0] dar_o,
    output logic        debug_entry_o,
    output logic        checkstop_o,
    output logic        freeze_o
);
    mc_outcome_e     outcome;
    logic [XLEN-1:0] srr1_n, msr_n, dsisr_n, vector_n;
    logic            live_evt;
    logic            stop_enter;

    mce_outcome_sel i_sel (
        .me_i          (msr_i[be(MSR_ME_BE)]),
        .dbg_mode_en_i (dbg_mode_en_i),
        .dbg_stop_en_i (dbg_stop_en_i),
        .dbg_mc_en_i   (dbg_mc_en_i),
        .outcome_o     (outcome)
    );

    mce_frame_build #(
        .LOW_BASE   (LOW_BASE),
        .HIGH_BASE  (HIGH_BASE),
        .VEC_OFFSET (VEC_OFFSET)
    ) i_build (
        .msr_i       (msr_i),
        .insn_i      (insn_i),
        .fetch_err_i (fetch_err_i),
        .x_form_i    (x_form_i),
        .srr1_o      (srr1_n),
        .msr_o       (msr_n),
        .dsisr_o     (dsisr_n),
        .vector_o    (vector_n)
    );

    // Purpose: events are dropped once the core is checkstopped.
    always_comb begin
        live_evt   = mc_event_i && !checkstop_o;
        stop_enter = live_evt && (outcome == MC_STOP);
    end

    mce_stop_hold #(.FREEZE_DLY(FREEZE_DLY)) i_stop (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (stop_enter),
        .checkstop_o (checkstop_o),
        .freeze_o    (freeze_o)
    );

    // Purpose: one-cycle strobes for redirect, DSISR/DAR write and debug entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o     <= 1'b0;
            dsisr_dar_we_o <= 1'b0;
            debug_entry_o  <= 1'b0;
        end else begin
            redirect_o     <= live_evt && (outcome == MC_TAKE);
            dsisr_dar_we_o <= live_evt && (outcome == MC_TAKE) && !fetch_err_i;
            debug_entry_o  <= live_evt && (outcome == MC_DEBUG);
        end
    end

    // Purpose: capture the exception frame when the exception is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_pc_o <= '0;
            srr0_o        <= '0;
            srr1_o        <= '0;
            msr_o         <= '0;
        end else if (live_evt && (outcome == MC_TAKE)) begin
            redirect_pc_o <= vector_n;
            srr0_o        <= insn_ea_i;
            srr1_o        <= srr1_n;
            msr_o         <= msr_n;
        end
    end

    // Purpose: capture DSISR and DAR for load/store errors only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsisr_o <= '0;
            dar_o   <= '0;
        end else if (live_evt && (outcome == MC_TAKE) && !fetch_err_i) begin
            dsisr_o <= dsisr_n;
            dar_o   <= data_ea_i;
        end
    end

    // R1
    one_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect_o, debug_entry_o}));
    // R10
    no_act_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o && $past(checkstop_o) |-> !redirect_o && !debug_entry_o);
    // R7
    me_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !msr_o[be(MSR_ME_BE)]);
    // R6
    srr1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !srr1_o[be(0)] && (srr1_o[be(1)] == !dsisr_dar_we_o));
    // R4
    vector_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> redirect_pc_o[11:0] == VEC_OFFSET[11:0]);
    // R9
    we_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsisr_dar_we_o |-> redirect_o);
endmodule

// File: tb/test_mce_entry_ctrl.sv
module test_mce_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_event_i = 1'b0, fetch_err_i = 1'b0, x_form_i = 1'b0;
    logic [31:0] insn_i = '0, insn_ea_i = '0, data_ea_i = '0, msr_i = '0;
    logic dbg_mode_en_i = 1'b0, dbg_stop_en_i = 1'b0, dbg_mc_en_i = 1'b0;
    logic redirect_o, dsisr_dar_we_o, debug_entry_o, checkstop_o, freeze_o;
    logic [31:0] redirect_pc_o, srr0_o, srr1_o, msr_o, dsisr_o, dar_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    mce_entry_ctrl i_mce_entry_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        mc_event_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R11 reset state
        check("R11 redirect", 32'(redirect_o), 0);
        check("R11 dsisr_we", 32'(dsisr_dar_we_o), 0);
        check("R11 debug", 32'(debug_entry_o), 0);
        check("R11 checkstop", 32'(checkstop_o), 0);
        check("R11 freeze", 32'(freeze_o), 0);

        for (int cfg = 0; cfg < 256; cfg++) begin
            logic me, dm, cs, mc, ip, ile, fe, xf;
            logic exp_take, exp_stop, exp_dbg;
            logic [31:0] exp_dsisr, msr_v;
            {me, dm, cs, mc, ip, ile, fe, xf} = 8'(cfg);
            exp_dbg  = dm && ((!me && cs) || (me && mc));
            exp_stop = !me && (!dm || !cs);
            exp_take = !exp_dbg && !exp_stop;

            do_reset();
            seed = nxt(seed); msr_v = seed;
            msr_v[31-19] = me; msr_v[31-25] = ip; msr_v[31-15] = ile;
            seed = nxt(seed); insn_i = seed;
            seed = nxt(seed); insn_ea_i = seed;
            seed = nxt(seed); data_ea_i = seed;
            msr_i = msr_v; fetch_err_i = fe; x_form_i = xf;
            dbg_mode_en_i = dm; dbg_stop_en_i = cs; dbg_mc_en_i = mc;
            mc_event_i = 1'b1;
            @(negedge clk);
            mc_event_i = 1'b0;

            check("R1 redirect", 32'(redirect_o), 32'(exp_take));
            check("R2 checkstop", 32'(checkstop_o), 32'(exp_stop));
            check("R3 debug", 32'(debug_entry_o), 32'(exp_dbg));
            check("R9 dsisr_we", 32'(dsisr_dar_we_o), 32'(exp_take && !fe));
            if (exp_take) begin
                check("R4 vector", redirect_pc_o, ip ? 32'hFFF0_0200 : 32'h0000_0200);
                check("R5 srr0", srr0_o, insn_ea_i);
                check("R6 srr1", srr1_o, (32'(fe) << 30) | (msr_v & 32'h0000_FFFF));
                check("R7 msr", msr_o, (32'(ip) << 6) | 32'(ile));
                if (!fe) begin
                    exp_dsisr = ((insn_i >> 16) & 32'h3FF);
                    if (xf) exp_dsisr |= (((insn_i >> 1) & 32'h3) << 15) | (((insn_i >> 6) & 32'h1) << 14);
                    else    exp_dsisr |= ((insn_i >> 26) & 32'h1) << 14;
                    check("R8 dsisr", dsisr_o, exp_dsisr);
                    check("R9 dar", dar_o, data_ea_i);
                end else begin
                    // R9 fetch error: DSISR/DAR keep their reset value
                    check("R9 dsisr kept", dsisr_o, 32'h0);
                    check("R9 dar kept", dar_o, 32'h0);
                end
            end
            @(negedge clk);
            check("R1 single pulse", 32'(redirect_o), 0);
            check("R3 single pulse", 32'(debug_entry_o), 0);
            if (exp_stop) begin
                check("R10 freeze", 32'(freeze_o), 1);
                // R10 event while stopped that would otherwise be taken
                msr_i[31-19] = 1'b1; dbg_mode_en_i = 1'b0;
                mc_event_i = 1'b1;
                @(negedge clk);
                mc_event_i = 1'b0;
                check("R10 ignored redirect", 32'(redirect_o), 0);
                check("R10 ignored debug", 32'(debug_entry_o), 0);
                repeat (3) @(negedge clk);
                check("R10 sticky", 32'(checkstop_o), 1);
                do_reset();
                check("R11 stop cleared", 32'(checkstop_o), 0);
                check("R11 freeze cleared", 32'(freeze_o), 0);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule